// File: doc/BRIEF.md
# Bus Fault Resolution Controller

This block decides how a bus cycle that has been flagged as failed is resolved. It watches an active-low bus-error line and an active-low halt line, and it brings each one into the clock domain through its own synchronizer chain. When a bus error arrives during an active cycle, the block ends that cycle. What happens next depends on whether halt was already present.

If halt is absent when the error is evaluated, the block raises a one-clock exception request and is ready again at once. If halt was raised before the error, or together with it, the block withdraws the output enable of the address and data drivers and waits with nothing pending. Once halt goes away, it issues a one-clock rerun request. That request carries the address and transfer direction of the cycle that failed, so the sequencer can repeat it.

The surrounding sequencer supplies the cycle-active flag together with the address and direction of the cycle. It consumes the terminate, exception and rerun pulses.

Top module: `bus_fault_ctrl`

## Requirements
- R1: During reset and right after it, bus_oe_o is 1 and cyc_term_o, exc_req_o and rerun_req_o are 0. A reset applied while the buses are floated restores bus_oe_o to 1, and a later release of halt then produces no rerun.
- R2: berr_n_i and halt_n_i are active low, each passing through SYNC_STAGES flops. With SYNC_STAGES=2, a bus error driven low before clock edge k produces cyc_term_o high after edge k+2. That is a latency of SYNC_STAGES+1 edges.
- R3: If halt is not asserted in the cycle where the synchronized error is evaluated, the block raises exc_req_o for exactly one clock together with cyc_term_o and keeps bus_oe_o at 1. This includes halt arriving one clock after the error.
- R4: If halt was asserted before the error or on the same clock, the block raises cyc_term_o without exc_req_o, and bus_oe_o drops to 0 from the terminate cycle.
- R5: While halt stays asserted after a retry fault, bus_oe_o stays 0 and no rerun_req_o is issued.
- R6: When halt is released, rerun_req_o is high for exactly one clock, SYNC_STAGES+1 edges after the release. bus_oe_o is 1 in that same cycle and afterwards.
- R7: During the rerun pulse, rerun_addr_o and rerun_write_o equal the cyc_addr_i and cyc_write_i that were present when the fault was taken.
- R8: A bus error while cyc_active_i is 0 produces no terminate, exception or rerun.
- R9: A bus error held low for many clocks causes only one termination until it has been released.
- R10: exc_req_o and rerun_req_o are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_active_i | input | 1 | A bus cycle is in progress |
| cyc_addr_i | input | ADDR_W | Address of the current cycle |
| cyc_write_i | input | 1 | Direction of the current cycle, 1 = write |
| berr_n_i | input | 1 | Bus error, active low, asynchronous |
| halt_n_i | input | 1 | Halt, active low, asynchronous |
| bus_oe_o | output | 1 | Enable for the address and data drivers, 0 = floated |
| cyc_term_o | output | 1 | One-clock pulse ending the failed cycle |
| exc_req_o | output | 1 | One-clock bus-error exception request |
| rerun_req_o | output | 1 | One-clock request to repeat the failed cycle |
| rerun_addr_o | output | ADDR_W | Saved address of the failed cycle |
| rerun_write_o | output | 1 | Saved direction of the failed cycle |

## Verification
The bench builds the block with its defaults, ADDR_W=24 and SYNC_STAGES=2, and derives every expected latency from SYNC_STAGES+1. Two synchronizer stages are enough to separate a halt raised two clocks early, on the same clock, and one clock late relative to the error, which covers both the abort and retry decisions. The full 24-bit width makes all-ones and mixed addresses reachable in the rerun payload.

// File: rtl/bfc_pkg.sv
package bfc_pkg;
  typedef enum logic {
    BF_IDLE  = 1'b0,
    BF_FLOAT = 1'b1
  } bf_state_e;
endpackage

// File: rtl/bfc_sync.sv
module bfc_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      assign chain_d[i] = d_i;
    end else begin : g_next
      assign chain_d[i] = chain_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/bfc_hold.sv
module bfc_hold #(
  parameter int W = 25
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] hold_q;
  logic [W-1:0] hold_d;

  always_comb begin
    hold_d = hold_q;
    if (en_i) hold_d = d_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else        hold_q <= hold_d;
  end

  assign q_o = hold_q;
endmodule

// File: rtl/bfc_fsm.sv
module bfc_fsm
  import bfc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_active_i,
  input  logic berr_s_i,
  input  logic halt_s_i,
  output logic take_o,
  output logic bus_oe_o,
  output logic term_o,
  output logic exc_o,
  output logic rerun_o
);
  bf_state_e state_q, state_d;
  logic      seen_q, seen_d;
  logic      term_q, term_d;
  logic      exc_q, exc_d;
  logic      rerun_q, rerun_d;
  logic      take;

  // A fault is taken once per error assertion, only in an active cycle.
  assign take = berr_s_i && cyc_active_i && !seen_q && (state_q == BF_IDLE);

  always_comb begin
    state_d = state_q;
    term_d  = 1'b0;
    exc_d   = 1'b0;
    rerun_d = 1'b0;
    seen_d  = berr_s_i ? (seen_q | take) : 1'b0;
    case (state_q)
      BF_IDLE: begin
        if (take) begin
          term_d = 1'b1;
          if (halt_s_i) state_d = BF_FLOAT;
          else          exc_d   = 1'b1;
        end
      end
      BF_FLOAT: begin
        if (!halt_s_i) begin
          rerun_d = 1'b1;
          state_d = BF_IDLE;
        end
      end
      default: state_d = BF_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= BF_IDLE;
      seen_q  <= 1'b0;
      term_q  <= 1'b0;
      exc_q   <= 1'b0;
      rerun_q <= 1'b0;
    end else begin
      state_q <= state_d;
      seen_q  <= seen_d;
      term_q  <= term_d;
      exc_q   <= exc_d;
      rerun_q <= rerun_d;
    end
  end

  assign take_o   = take;
  assign bus_oe_o = (state_q != BF_FLOAT);
  assign term_o   = term_q;
  assign exc_o    = exc_q;
  assign rerun_o  = rerun_q;
endmodule

// File: rtl/bus_fault_ctrl.sv
module bus_fault_ctrl #(
  parameter int ADDR_W      = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_active_i,
  input  logic [ADDR_W-1:0] cyc_addr_i,
  input  logic              cyc_write_i,
  input  logic              berr_n_i,
  input  logic              halt_n_i,
  output logic              bus_oe_o,
  output logic              cyc_term_o,
  output logic              exc_req_o,
  output logic              rerun_req_o,
  output logic [ADDR_W-1:0] rerun_addr_o,
  output logic              rerun_write_o
);
  localparam int SAVE_W = ADDR_W + 1;

  logic              berr_n_s;
  logic              halt_n_s;
  logic              take;
  logic [SAVE_W-1:0] save_q;

  bfc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_berr_sync (
    .clk(clk), .rst_n(rst_n), .d_i(berr_n_i), .q_o(berr_n_s)
  );

  bfc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_halt_sync (
    .clk(clk), .rst_n(rst_n), .d_i(halt_n_i), .q_o(halt_n_s)
  );

  bfc_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .cyc_active_i (cyc_active_i),
    .berr_s_i     (~berr_n_s),
    .halt_s_i     (~halt_n_s),
    .take_o       (take),
    .bus_oe_o     (bus_oe_o),
    .term_o       (cyc_term_o),
    .exc_o        (exc_req_o),
    .rerun_o      (rerun_req_o)
  );

  bfc_hold #(.W(SAVE_W)) u_save (
    .clk   (clk),
    .rst_n (rst_n),
    .en_i  (take),
    .d_i   ({cyc_write_i, cyc_addr_i}),
    .q_o   (save_q)
  );

  assign rerun_addr_o  = save_q[ADDR_W-1:0];
  assign rerun_write_o = save_q[ADDR_W];
endmodule

// File: rtl/bfc_checker.sv
module bfc_checker (
  input logic clk,
  input logic rst_n,
  input logic cyc_active_i,
  input logic bus_oe_o,
  input logic cyc_term_o,
  input logic exc_req_o,
  input logic rerun_req_o
);
  AST_EXC_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req_o |=> !exc_req_o); // R3
  AST_EXC_ENDS_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req_o |-> (cyc_term_o && bus_oe_o)); // R3
  AST_FLOAT_STARTS_AT_TERM: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_oe_o) |-> (cyc_term_o && !exc_req_o)); // R4
  AST_FLOAT_NO_RERUN: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe_o |-> !rerun_req_o); // R5
  AST_RERUN_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    rerun_req_o |=> !rerun_req_o); // R6
  AST_RERUN_AFTER_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    rerun_req_o |-> (bus_oe_o && !$past(bus_oe_o))); // R6
  AST_TERM_NEEDS_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_term_o |-> $past(cyc_active_i)); // R8
  AST_TERM_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_term_o |=> !cyc_term_o); // R9
  AST_EXC_RERUN_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(exc_req_o && rerun_req_o)); // R10
endmodule

bind bus_fault_ctrl bfc_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cyc_active_i (cyc_active_i),
  .bus_oe_o     (bus_oe_o),
  .cyc_term_o   (cyc_term_o),
  .exc_req_o    (exc_req_o),
  .rerun_req_o  (rerun_req_o)
);

// File: tb/bus_fault_ctrl_tb.sv
module bus_fault_ctrl_tb;
  localparam int ADDR_W      = 24;
  localparam int SYNC_STAGES = 2;
  localparam int LAT         = SYNC_STAGES + 1;
  localparam int NVEC        = 8;

  // [31]=cycle active, [30:29]=halt timing (0 none,1 same clock,2 two early,3 one late),
  // [28]=write, [23:0]=address
  localparam logic [31:0] VEC [NVEC] = '{
    {1'b1, 2'd0, 1'b0, 4'h0, 24'h001234},
    {1'b1, 2'd1, 1'b0, 4'h0, 24'h00A5A4},
    {1'b1, 2'd2, 1'b1, 4'h0, 24'h3C0F00},
    {1'b1, 2'd3, 1'b1, 4'h0, 24'h777776},
    {1'b0, 2'd0, 1'b0, 4'h0, 24'h000010},
    {1'b0, 2'd2, 1'b1, 4'h0, 24'h000020},
    {1'b1, 2'd1, 1'b1, 4'h0, 24'h800002},
    {1'b1, 2'd2, 1'b0, 4'h0, 24'hFFFFFF}
  };

  logic              clk;
  logic              rst_n;
  logic              cyc_active_i;
  logic [ADDR_W-1:0] cyc_addr_i;
  logic              cyc_write_i;
  logic              berr_n_i;
  logic              halt_n_i;
  logic              bus_oe_o;
  logic              cyc_term_o;
  logic              exc_req_o;
  logic              rerun_req_o;
  logic [ADDR_W-1:0] rerun_addr_o;
  logic              rerun_write_o;

  int n_chk;
  int n_bad;

  bus_fault_ctrl #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) u_dut (
    .clk(clk), .rst_n(rst_n), .cyc_active_i(cyc_active_i), .cyc_addr_i(cyc_addr_i),
    .cyc_write_i(cyc_write_i), .berr_n_i(berr_n_i), .halt_n_i(halt_n_i),
    .bus_oe_o(bus_oe_o), .cyc_term_o(cyc_term_o), .exc_req_o(exc_req_o),
    .rerun_req_o(rerun_req_o), .rerun_addr_o(rerun_addr_o), .rerun_write_o(rerun_write_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  task automatic run_vec(input logic [31:0] v);
    bit       act;
    bit [1:0] mode;
    bit       retry;
    int       term_cnt, term_at, exc_cnt, early_rr, hold_rr, rr_cnt, rr_at;
    logic     oe_end, oe_at_rr, rr_write, oe_final;
    logic [ADDR_W-1:0] rr_addr;
    act   = v[31];
    mode  = v[30:29];
    retry = act && (mode == 2'd1 || mode == 2'd2);
    term_cnt = 0; term_at = -1; exc_cnt = 0; early_rr = 0; hold_rr = 0;
    rr_cnt = 0; rr_at = -1; oe_at_rr = 1'b0; rr_write = 1'b0; rr_addr = '0;
    @(negedge clk);
    cyc_addr_i   = v[23:0];
    cyc_write_i  = v[28];
    cyc_active_i = act;
    if (mode == 2'd2) begin
      halt_n_i = 1'b0;
      repeat (2) @(negedge clk);
    end
    berr_n_i = 1'b0;
    if (mode == 2'd1) halt_n_i = 1'b0;
    for (int i = 1; i <= 8; i++) begin
      @(negedge clk);
      if (cyc_term_o) begin term_cnt++; term_at = i; end
      if (exc_req_o) exc_cnt++;
      if (rerun_req_o) early_rr++;
      if (i == 1 && mode == 2'd3) halt_n_i = 1'b0;
    end
    oe_end = bus_oe_o;
    berr_n_i = 1'b1;
    cyc_active_i = 1'b0;
    for (int i = 1; i <= 4; i++) begin
      @(negedge clk);
      if (rerun_req_o || (retry && bus_oe_o)) hold_rr++;
    end
    halt_n_i = 1'b1;
    for (int i = 1; i <= 8; i++) begin
      @(negedge clk);
      if (rerun_req_o) begin
        rr_cnt++; rr_at = i; rr_addr = rerun_addr_o; rr_write = rerun_write_o;
        oe_at_rr = bus_oe_o;
      end
    end
    oe_final = bus_oe_o;
    check(term_cnt == (act ? 1 : 0), act ? "R9 single termination" : "R8 inactive ignored",
          term_cnt, act ? 1 : 0);
    if (act) check(term_at == LAT, "R2 terminate latency", term_at, LAT);
    check(exc_cnt == ((act && !retry) ? 1 : 0), "R3 exception count", exc_cnt,
          (act && !retry) ? 1 : 0);
    check(oe_end == !retry, "R4 bus enable after fault", oe_end, !retry);
    check(early_rr == 0 && hold_rr == 0, "R5 floated while halted", early_rr + hold_rr, 0);
    check(rr_cnt == (retry ? 1 : 0), "R6 rerun count", rr_cnt, retry ? 1 : 0);
    if (retry) begin
      check(rr_at == LAT, "R6 rerun latency", rr_at, LAT);
      check(oe_at_rr == 1'b1, "R6 enable at rerun", oe_at_rr, 1);
      check(rr_addr == v[23:0], "R7 rerun address", rr_addr, v[23:0]);
      check(rr_write == v[28], "R7 rerun direction", rr_write, v[28]);
    end
    check(oe_final == 1'b1, "R6 enable restored", oe_final, 1);
    check(rr_cnt <= 1 && !(exc_cnt != 0 && rr_cnt != 0), "R10 exclusive outcome",
          exc_cnt + rr_cnt, retry || act ? 1 : 0);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    int cnt;
    n_chk = 0;
    n_bad = 0;
    rst_n = 1'b0;
    cyc_active_i = 1'b0;
    cyc_addr_i = '0;
    cyc_write_i = 1'b0;
    berr_n_i = 1'b1;
    halt_n_i = 1'b1;
    repeat (3) @(negedge clk);
    check(bus_oe_o == 1'b1, "R1 reset enable", bus_oe_o, 1);
    check({cyc_term_o, exc_req_o, rerun_req_o} == 3'b000, "R1 reset pulses",
          {cyc_term_o, exc_req_o, rerun_req_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(bus_oe_o == 1'b1 && !cyc_term_o, "R1 after release", bus_oe_o, 1);

    for (int k = 0; k < NVEC; k++) run_vec(VEC[k]);

    // R9: error held for a long time with an active cycle and no halt
    cnt = 0;
    cyc_active_i = 1'b1;
    cyc_addr_i = 24'h00ABCD;
    berr_n_i = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (exc_req_o) cnt++;
    end
    check(cnt == 1, "R9 held error one exception", cnt, 1);
    berr_n_i = 1'b1;
    cyc_active_i = 1'b0;
    repeat (5) @(negedge clk);

    // R1: reset while floated, then halt release gives no rerun
    cyc_active_i = 1'b1;
    halt_n_i = 1'b0;
    berr_n_i = 1'b0;
    repeat (LAT + 2) @(negedge clk);
    check(bus_oe_o == 1'b0, "R4 floated before reset", bus_oe_o, 0);
    rst_n = 1'b0;
    #1;
    check(bus_oe_o == 1'b1, "R1 reset while floated", bus_oe_o, 1);
    berr_n_i = 1'b1;
    cyc_active_i = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    halt_n_i = 1'b1;
    cnt = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (rerun_req_o || !bus_oe_o) cnt++;
    end
    check(cnt == 0, "R1 no rerun after reset", cnt, 0);

    finish_run();
  end
endmodule